// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms memory addresses for a CPU core that has two index registers and two addressing widths. An indexed access adds a signed 8-bit offset to one of the two index registers. In the 24-bit wide mode the sum is a full 24-bit address. In the legacy 16-bit mode the sum wraps within 16 bits, and an 8-bit page register supplies the top byte. A second output gives the vectored-interrupt table address. It is built from a 16-bit interrupt page register and the 8-bit vector byte that the interrupting device places on the bus.

The block also holds the architectural state that these addresses depend on. That state is the two 24-bit index registers, the page register and the interrupt page register. Software can write each index register whole or one byte at a time. It reads them back through one selectable read port. The page register can only be changed while the core runs in the wide mode. Both address outputs are combinational. All register writes take effect on the rising clock edge.

Top module: `idx_ea_gen`

## Requirements
- R1: After a synchronous active-low reset, both index registers, the page register and the interrupt page register read as zero.
- R2: In wide mode (`wide_mode`=1), `ea` equals the selected index register plus the sign-extended `disp`, modulo 2^24. `idx_sel`=0 selects the first index register and `idx_sel`=1 selects the second.
- R3: A `disp` with bit 7 set is negative (two's complement), so 8'hFF subtracts one and 8'h80 subtracts 128.
- R4: In legacy mode (`wide_mode`=0), `ea[23:16]` is the page register, and `ea[15:0]` is the low 16 bits of the selected index register plus the sign-extended `disp`, modulo 2^16. The sum never carries into the page byte.
- R5: Byte targets write `wr_data[7:0]`. Code 2 writes bits 15:8 of the first index register, code 3 bits 7:0 of it, code 4 bits 15:8 of the second, and code 5 bits 7:0 of the second. The other bytes of that register keep their values. Reading a byte code returns that byte zero-extended on `rd_data`.
- R6: A page-register write (code 6, data in `wr_data[7:0]`) takes effect only while `wide_mode`=1. In legacy mode it leaves the page register unchanged. Code 6 reads it back zero-extended.
- R7: `vec_addr` equals the interrupt page register concatenated with `vec_byte` (the vector byte is bits 7:0).
- R8: Whole-register writes (code 0 for the first index register, code 1 for the second) load all 24 bits in wide mode. In legacy mode they load only bits 15:0 and keep bits 23:16. Reading code 0 or 1 returns the full 24 bits.
- R9: An interrupt page write (code 7) loads `wr_data[15:0]` in either mode, and code 7 reads it back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode | input | 1 | 1 = 24-bit mode, 0 = legacy 16-bit mode |
| idx_sel | input | 1 | Index register used for `ea` (0 first, 1 second) |
| disp | input | 8 | Two's-complement displacement |
| vec_byte | input | 8 | Vector byte from the interrupting device |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 3 | Write target code (see R5, R6, R8, R9) |
| wr_data | input | 24 | Write data |
| rd_sel | input | 3 | Read target code, same coding as writes |
| ea | output | 24 | Indexed effective address |
| vec_addr | output | 24 | Vector table entry address |
| rd_data | output | 24 | Selected register or byte, zero-extended |

## Verification
Displacements of zero, +127, -128 and -1 are applied to both index registers in both modes. These show whether the offset is sign-extended and whether the right register is chosen. Index values just below 2^16 and 2^24, paired with positive offsets, show whether a legacy sum leaks a carry into the page byte and whether a wide sum wraps correctly. Page writes attempted in legacy mode, and whole-register writes in legacy mode, show that mode gating acts on the right target. A long random run mixes writes, byte writes and mode changes, and each cycle is compared with a behavioural model.

// File: rtl/iea_pkg.sv
// Shared definitions for the indexed effective address generator.
// Assumes write and read target codes are 3 bits wide.
package iea_pkg;
    typedef enum logic [2:0] {
        TGT_IX_ALL  = 3'd0,
        TGT_IY_ALL  = 3'd1,
        TGT_IX_HI   = 3'd2,
        TGT_IX_LO   = 3'd3,
        TGT_IY_HI   = 3'd4,
        TGT_IY_LO   = 3'd5,
        TGT_PAGE    = 3'd6,
        TGT_IPAGE   = 3'd7
    } reg_tgt_e;
endpackage

// File: rtl/iea_index_file.sv
// Two index registers with whole and per-byte write access.
// Assumes ADDR_W >= LOW_W >= 2*BYTE_W; byte data comes from wr_data[BYTE_W-1:0].
// A whole write in legacy mode updates only the low LOW_W bits.
module iea_index_file
    import iea_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              wr_en,
    input  reg_tgt_e          wr_tgt,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ix_q,
    output logic [ADDR_W-1:0] iy_q
);
    localparam int NREG = 2;

    logic [ADDR_W-1:0] idx_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_idx
        localparam reg_tgt_e T_ALL = (g == 0) ? TGT_IX_ALL : TGT_IY_ALL;
        localparam reg_tgt_e T_HI  = (g == 0) ? TGT_IX_HI  : TGT_IY_HI;
        localparam reg_tgt_e T_LO  = (g == 0) ? TGT_IX_LO  : TGT_IY_LO;

        // Update this index register on a whole or byte write aimed at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
            end else if (wr_en) begin
                if (wr_tgt == T_ALL) begin
                    if (wide_mode) idx_q[g] <= wr_data;
                    else           idx_q[g][LOW_W-1:0] <= wr_data[LOW_W-1:0];
                end else if (wr_tgt == T_HI) begin
                    idx_q[g][2*BYTE_W-1:BYTE_W] <= wr_data[BYTE_W-1:0];
                end else if (wr_tgt == T_LO) begin
                    idx_q[g][BYTE_W-1:0] <= wr_data[BYTE_W-1:0];
                end
            end
        end
    end

    assign ix_q = idx_q[0];
    assign iy_q = idx_q[1];
endmodule

// File: rtl/iea_page_regs.sv
// Page register (legacy-mode upper address byte) and interrupt page register.
// Assumes the page register may only be written while wide_mode is high.
module iea_page_regs
    import iea_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PAGE_W  = 8,
    parameter int IPAGE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_mode,
    input  logic               wr_en,
    input  reg_tgt_e           wr_tgt,
    input  logic [ADDR_W-1:0]  wr_data,
    output logic [PAGE_W-1:0]  page_q,
    output logic [IPAGE_W-1:0] ipage_q
);
    // Load the page register only on a wide-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      page_q <= '0;
        else if (wr_en && wr_tgt == TGT_PAGE && wide_mode) page_q <= wr_data[PAGE_W-1:0];
    end

    // Load the interrupt page register in either mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ipage_q <= '0;
        else if (wr_en && wr_tgt == TGT_IPAGE) ipage_q <= wr_data[IPAGE_W-1:0];
    end
endmodule

// File: rtl/iea_addr_calc.sv
// Combinational indexed address: base plus sign-extended displacement.
// Legacy mode wraps within LOW_W bits and prefixes the page register.
module iea_addr_calc #(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8,
    parameter int DISP_W = 8
) (
    input  logic              wide_mode,
    input  logic              idx_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] ix_q,
    input  logic [ADDR_W-1:0] iy_q,
    input  logic [PAGE_W-1:0] page_q,
    output logic [ADDR_W-1:0] ea
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum_wide;
    logic [LOW_W-1:0]  sum_low;

    // Pick the base, sign-extend the offset, and form both width variants.
    always_comb begin
        base     = idx_sel ? iy_q : ix_q;
        disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        sum_wide = base + disp_ext;
        sum_low  = base[LOW_W-1:0] + disp_ext[LOW_W-1:0];
        ea       = wide_mode ? sum_wide : {page_q, sum_low};
    end
endmodule

// File: rtl/idx_ea_gen.sv
// Top of the indexed effective address generator.
// Holds index, page and interrupt page registers, forms the indexed and
// vector-table addresses, and provides one zero-extending read port.
module idx_ea_gen
    import iea_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8,
    parameter int DISP_W = 8,
    parameter int VEC_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              idx_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [VEC_W-1:0]  vec_byte,
    input  logic              wr_en,
    input  logic [2:0]        wr_target,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int LOW_W   = ADDR_W - PAGE_W;
    localparam int IPAGE_W = ADDR_W - VEC_W;

    reg_tgt_e           wr_tgt;
    reg_tgt_e           rd_tgt;
    logic [ADDR_W-1:0]  ix_q;
    logic [ADDR_W-1:0]  iy_q;
    logic [PAGE_W-1:0]  page_q;
    logic [IPAGE_W-1:0] ipage_q;

    assign wr_tgt = reg_tgt_e'(wr_target);
    assign rd_tgt = reg_tgt_e'(rd_sel);

    iea_index_file #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .BYTE_W(BYTE_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wr_en(wr_en),
        .wr_tgt(wr_tgt), .wr_data(wr_data), .ix_q(ix_q), .iy_q(iy_q)
    );

    iea_page_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IPAGE_W(IPAGE_W)) u_pg (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wr_en(wr_en),
        .wr_tgt(wr_tgt), .wr_data(wr_data), .page_q(page_q), .ipage_q(ipage_q)
    );

    iea_addr_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W)) u_calc (
        .wide_mode(wide_mode), .idx_sel(idx_sel), .disp(disp),
        .ix_q(ix_q), .iy_q(iy_q), .page_q(page_q), .ea(ea)
    );

    assign vec_addr = {ipage_q, vec_byte};

    // Read port: full index registers, or a zero-extended byte or page value.
    always_comb begin
        rd_data = '0;
        case (rd_tgt)
            TGT_IX_ALL: rd_data = ix_q;
            TGT_IY_ALL: rd_data = iy_q;
            TGT_IX_HI:  rd_data[BYTE_W-1:0] = ix_q[2*BYTE_W-1:BYTE_W];
            TGT_IX_LO:  rd_data[BYTE_W-1:0] = ix_q[BYTE_W-1:0];
            TGT_IY_HI:  rd_data[BYTE_W-1:0] = iy_q[2*BYTE_W-1:BYTE_W];
            TGT_IY_LO:  rd_data[BYTE_W-1:0] = iy_q[BYTE_W-1:0];
            TGT_PAGE:   rd_data[PAGE_W-1:0] = page_q;
            TGT_IPAGE:  rd_data[IPAGE_W-1:0] = ipage_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/iea_checker.sv
// Assertion checker for idx_ea_gen, attached by bind below.
module iea_checker #(
    parameter int ADDR_W = 24,
    parameter int PAGE_W = 8,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic              idx_sel,
    input logic [DISP_W-1:0] disp,
    input logic              wr_en,
    input logic [2:0]        wr_target,
    input logic [ADDR_W-1:0] ea,
    input logic [ADDR_W-1:0] ix_q,
    input logic [ADDR_W-1:0] iy_q,
    input logic [PAGE_W-1:0] page_q
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    // R1: reset clears the stored state
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ix_q == '0 && iy_q == '0 && page_q == '0));

    // R2: zero offset in wide mode yields the selected register unchanged
    a_r2_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && disp == '0) |-> (ea == (idx_sel ? iy_q : ix_q)));

    // R4: legacy mode top byte always comes from the page register
    a_r4_page_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (ea[ADDR_W-1:LOW_W] == page_q));

    // R5: a high-byte write to the first index register leaves its other bytes
    a_r5_hi_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_target == 3'd2) |=>
            (ix_q[7:0] == $past(ix_q[7:0]) && ix_q[ADDR_W-1:16] == $past(ix_q[ADDR_W-1:16])));

    // R6: page write in legacy mode is ignored
    a_r6_page_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_target == 3'd6 && !wide_mode) |=> $stable(page_q));

    // R8: legacy whole write to the second index register keeps its top byte
    a_r8_legacy_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_target == 3'd1 && !wide_mode) |=>
            (iy_q[ADDR_W-1:LOW_W] == $past(iy_q[ADDR_W-1:LOW_W])));
endmodule

bind idx_ea_gen iea_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .idx_sel(idx_sel),
    .disp(disp), .wr_en(wr_en), .wr_target(wr_target), .ea(ea),
    .ix_q(ix_q), .iy_q(iy_q), .page_q(page_q)
);

// File: tb/idx_ea_gen_test.sv
module idx_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        idx_sel = 1'b0;
    logic [7:0]  disp = '0;
    logic [7:0]  vec_byte = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_target = '0;
    logic [23:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [23:0] ea, vec_addr, rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    int m_ix = 0, m_iy = 0, m_pg = 0, m_ip = 0;

    always #2 clk = ~clk;

    idx_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .idx_sel(idx_sel),
        .disp(disp), .vec_byte(vec_byte), .wr_en(wr_en), .wr_target(wr_target),
        .wr_data(wr_data), .rd_sel(rd_sel), .ea(ea), .vec_addr(vec_addr),
        .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ix <= 0; m_iy <= 0; m_pg <= 0; m_ip <= 0;
        end else if (wr_en) begin
            case (wr_target)
                3'd0: m_ix <= wide_mode ? int'(wr_data) : ((m_ix & 'hFF0000) | int'(wr_data[15:0]));
                3'd1: m_iy <= wide_mode ? int'(wr_data) : ((m_iy & 'hFF0000) | int'(wr_data[15:0]));
                3'd2: m_ix <= (m_ix & 'hFF00FF) | (int'(wr_data[7:0]) * 256);
                3'd3: m_ix <= (m_ix & 'hFFFF00) | int'(wr_data[7:0]);
                3'd4: m_iy <= (m_iy & 'hFF00FF) | (int'(wr_data[7:0]) * 256);
                3'd5: m_iy <= (m_iy & 'hFFFF00) | int'(wr_data[7:0]);
                3'd6: if (wide_mode) m_pg <= int'(wr_data[7:0]);
                default: m_ip <= int'(wr_data[15:0]);
            endcase
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %06h expected %06h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_ea();
        int base = idx_sel ? m_iy : m_ix;
        int sd = (disp > 8'd127) ? int'(disp) - 256 : int'(disp);
        if (wide_mode) return (base + sd) & 'hFFFFFF;
        return (m_pg * 65536) | (((base & 'hFFFF) + sd) & 'hFFFF);
    endfunction

    function automatic int exp_rd();
        case (rd_sel)
            3'd0: return m_ix;
            3'd1: return m_iy;
            3'd2: return (m_ix / 256) & 'hFF;
            3'd3: return m_ix & 'hFF;
            3'd4: return (m_iy / 256) & 'hFF;
            3'd5: return m_iy & 'hFF;
            3'd6: return m_pg;
            default: return m_ip;
        endcase
    endfunction

    function automatic string rd_req();
        case (rd_sel)
            3'd0, 3'd1: return "R8";
            3'd6:       return "R6";
            3'd7:       return "R9";
            default:    return "R5";
        endcase
    endfunction

    // compare every output against the model once per clock, mid-cycle
    task automatic compare_all();
        check(wide_mode ? (disp[7] ? "R3" : "R2") : "R4", int'(ea), exp_ea());
        check("R7", int'(vec_addr), m_ip * 256 + int'(vec_byte));
        check(rd_req(), int'(rd_data), exp_rd());
    endtask

    // drive one cycle of inputs at the falling edge, compare, then clock it in
    task automatic cyc(bit wm, bit sel, logic [7:0] d, bit we, logic [2:0] tg,
                       logic [23:0] wd, logic [2:0] rs);
        wide_mode = wm; idx_sel = sel; disp = d; wr_en = we;
        wr_target = tg; wr_data = wd; rd_sel = rs; vec_byte = d ^ 8'h5A;
        #1;
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int k = 0; k < 8; k++) begin
            rd_sel = 3'(k);
            #1;
            check("R1", int'(rd_data), 0);
            @(negedge clk);
        end
        // R8: wide whole writes
        cyc(1, 0, 8'h00, 1, 3'd0, 24'h123456, 3'd0);
        cyc(1, 0, 8'h00, 1, 3'd1, 24'hFEDCBA, 3'd0);
        // R2/R3: offsets on both registers
        for (int s = 0; s < 2; s++) begin
            cyc(1, s[0], 8'h00, 0, 3'd0, 0, 3'd1);
            cyc(1, s[0], 8'h7F, 0, 3'd0, 0, 3'd1);
            cyc(1, s[0], 8'h80, 0, 3'd0, 0, 3'd1);
            cyc(1, s[0], 8'hFF, 0, 3'd0, 0, 3'd1);
        end
        // R2: 24-bit wrap
        cyc(1, 0, 8'h00, 1, 3'd0, 24'hFFFFF0, 3'd0);
        cyc(1, 0, 8'h20, 0, 3'd0, 0, 3'd0);
        // R6: wide write lands, legacy write ignored
        cyc(1, 0, 8'h00, 1, 3'd6, 24'h0000A5, 3'd6);
        cyc(0, 0, 8'h00, 1, 3'd6, 24'h00003C, 3'd6);
        cyc(0, 0, 8'h00, 0, 3'd0, 0, 3'd6);
        // R4: legacy wrap stays out of the page byte
        cyc(0, 0, 8'h20, 0, 3'd0, 0, 3'd0);
        cyc(0, 0, 8'h80, 0, 3'd0, 0, 3'd0);
        // R8: legacy whole write keeps the top byte
        cyc(0, 1, 8'h00, 1, 3'd1, 24'h777777, 3'd1);
        cyc(0, 1, 8'h01, 0, 3'd0, 0, 3'd1);
        // R5: byte writes and reads
        cyc(1, 0, 8'h00, 1, 3'd2, 24'h0000C3, 3'd2);
        cyc(1, 0, 8'h00, 1, 3'd3, 24'h000011, 3'd0);
        cyc(1, 0, 8'h00, 1, 3'd4, 24'h000022, 3'd3);
        cyc(1, 0, 8'h00, 1, 3'd5, 24'h000033, 3'd4);
        cyc(1, 0, 8'h00, 0, 3'd0, 0, 3'd5);
        cyc(1, 0, 8'h00, 0, 3'd0, 0, 3'd1);
        // R9/R7: interrupt page and vector address
        cyc(0, 0, 8'h00, 1, 3'd7, 24'h12BEEF, 3'd7);
        cyc(0, 0, 8'hA5, 0, 3'd0, 0, 3'd7);
        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            cyc(1'($urandom), 1'($urandom), 8'($urandom), ($urandom % 3) == 0,
                3'($urandom), 24'($urandom), 3'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule